// File: doc/BRIEF.md
# RTC Interrupt Emulation Sequencer

This block rebuilds the three interrupt kinds of a classic real-time clock (update-ended, alarm match and periodic) from a fast free-running reference count and the current time of day. Each time the tick comparator is serviced, the block looks at the current hours, minutes and seconds, the alarm registers, the three enables and the requested periodic rate. It then decides which flags to raise and presents a registered status word with a one-cycle interrupt strobe.

The block keeps its own tick deadline, expressed in reference-count units. The reference count runs at 2^LOG_FAST Hz, which is 8192 Hz by default. The tick interval is 1/64 s. It is shorter only when periodic mode asks for a rate above 64 Hz. Slower periodic rates are made by dividing down the 64 Hz tick. A service that arrives late advances the deadline by whole intervals. The skipped intervals are reported and are also added to the periodic divide-down count.

Top module: `rtc_irq_emu`

## Requirements
- R1: `chan_en` is high exactly when at least one of `upd_en`, `alm_en` and `per_en` is high. While all three are low, a `tick` raises no strobe and leaves `irq_status`, `next_deadline` and `lost_ticks` unchanged.
- R2: The tick interval is 2^(LOG_FAST-`rate_sel`) counts when `per_en` is high and `rate_sel` > 6. Otherwise it is 2^(LOG_FAST-6) counts, which is 128 by default. When the enables go from all low to any high, `next_deadline` becomes `now_cnt` plus one interval on the next clock.
- R3: For `rate_sel` <= 6 (2^`rate_sel` Hz), the periodic flag rises on every 2^(6-`rate_sel`)-th serviced tick, and the count restarts each time it fires. For `rate_sel` > 6 the flag rises on every serviced tick.
- R4: With `upd_en` high, the update flag rises on a tick where `cur_sec` differs from the last recorded seconds value. The first tick after `upd_en` rises only records the value and raises no flag.
- R5: With `alm_en` high, the alarm flag rises on a tick where hours, minutes and seconds all equal the alarm registers.
- R6: On a tick that raises any flag, `irq_strobe` pulses for one clock and `irq_status` is loaded with update flag = bit 4, alarm flag = bit 5, periodic flag = bit 6, summary = bit 7, 1 in bits 15:8 and 0 in bits 3:0. Without a strobe, `irq_status` holds its value.
- R7: On a serviced tick, `next_deadline` is advanced by the smallest whole number n >= 1 of intervals that leaves it at or ahead of `now_cnt` (signed difference). `lost_ticks` becomes n-1.
- R8: When `per_en` is high, the n-1 skipped intervals are added to the periodic count together with the serviced tick.
- R9: A change of `rate_sel` clears the periodic count, so the next periodic flag comes a full period later.
- R10: After reset, `irq_strobe`, `irq_status`, `next_deadline` and `lost_ticks` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Tick comparator service pulse |
| upd_en | input | 1 | Update interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| rate_sel | input | 4 | Periodic rate, 2^rate_sel Hz |
| now_cnt | input | 32 | Free-running reference count |
| cur_hr | input | 5 | Current hours |
| cur_min | input | 6 | Current minutes |
| cur_sec | input | 6 | Current seconds |
| alm_hr | input | 5 | Alarm hours |
| alm_min | input | 6 | Alarm minutes |
| alm_sec | input | 6 | Alarm seconds |
| chan_en | output | 1 | Tick channel enabled |
| next_deadline | output | 32 | Next tick deadline in reference counts |
| lost_ticks | output | 32 | Intervals skipped at the last serviced tick |
| irq_strobe | output | 1 | One-cycle interrupt pulse |
| irq_status | output | 16 | Packed interrupt status word |

## Verification
The update path is driven with a seconds value that first stays constant and then changes. This separates the suppressed first record from a real update flag. Alarm ticks are applied with a full match and then with a seconds mismatch, and the matching tick lands together with an update so that both bits are checked in one word. Periodic ticks run at three slow rates and one fast rate, with punctual, early and very late services. This tells whole-interval deadline advance and skipped-tick folding apart from plain counting. It also shows whether a rate change restarts the divide-down or keeps the stale count. Ticks applied with every enable low, and again after a full disable, confirm that the channel ignores them and re-arms when enabled again.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int UF_BIT  = 4;
  localparam int AF_BIT  = 5;
  localparam int PF_BIT  = 6;
  localparam int IRQ_BIT = 7;

  function automatic logic [15:0] pack_status(input logic uf, input logic af, input logic pf);
    logic [15:0] w;
    w = 16'h0100;
    w[UF_BIT]  = uf;
    w[AF_BIT]  = af;
    w[PF_BIT]  = pf;
    w[IRQ_BIT] = uf | af | pf;
    return w;
  endfunction
endpackage

// File: rtl/rtc_tick_sched.sv
module rtc_tick_sched #(
  parameter int CNT_W = 32,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             go,
  input  logic [CNT_W-1:0] now,
  input  logic [SH_W-1:0]  shamt,
  output logic [CNT_W-1:0] deadline,
  output logic [CNT_W-1:0] skip_n,
  output logic [CNT_W-1:0] lost
);
  logic [CNT_W-1:0] dl_q, dl_n, lost_q, lost_n;
  logic [CNT_W-1:0] ivl, diff, steps;

  always_comb begin
    ivl   = CNT_W'(1) << shamt;
    diff  = now - dl_q;
    steps = CNT_W'(1);
    if ($signed(diff) > $signed(ivl))
      steps = (diff + ivl - CNT_W'(1)) >> shamt;
    skip_n = steps - CNT_W'(1);
    dl_n   = dl_q;
    lost_n = lost_q;
    if (arm) begin
      dl_n = now + ivl;
    end else if (go) begin
      dl_n   = dl_q + (steps << shamt);
      lost_n = skip_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q   <= '0;
      lost_q <= '0;
    end else if (arm || go) begin
      dl_q   <= dl_n;
      lost_q <= lost_n;
    end
  end

  assign deadline = dl_q;
  assign lost     = lost_q;
endmodule

// File: rtl/rtc_pie_div.sv
module rtc_pie_div #(
  parameter int CNT_W = 32,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  logic [CNT_W-1:0] skip,
  input  logic [SH_W-1:0]  lim_log,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_n, sum, lim;

  always_comb begin
    lim   = CNT_W'(1) << lim_log;
    sum   = cnt_q + CNT_W'(1) + skip;
    fire  = 1'b0;
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (go) begin
      if (sum >= lim) begin
        fire  = 1'b1;
        cnt_n = '0;
      end else begin
        cnt_n = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || go) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/rtc_flag_eval.sv
module rtc_flag_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       upd_en,
  input  logic       upd_rise,
  input  logic       alm_en,
  input  logic [4:0] cur_hr,
  input  logic [5:0] cur_min,
  input  logic [5:0] cur_sec,
  input  logic [4:0] alm_hr,
  input  logic [5:0] alm_min,
  input  logic [5:0] alm_sec,
  output logic       uf,
  output logic       af
);
  logic       seen_q, seen_n;
  logic [5:0] sec_q, sec_n;

  always_comb begin
    uf     = 1'b0;
    seen_n = seen_q;
    sec_n  = sec_q;
    if (upd_rise) begin
      seen_n = 1'b0;
    end else if (go && upd_en && (!seen_q || cur_sec != sec_q)) begin
      uf     = seen_q;
      sec_n  = cur_sec;
      seen_n = 1'b1;
    end
    af = go && alm_en && (cur_hr == alm_hr) && (cur_min == alm_min) && (cur_sec == alm_sec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      sec_q  <= '0;
    end else begin
      seen_q <= seen_n;
      sec_q  <= sec_n;
    end
  end
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu #(
  parameter int CNT_W    = 32,
  parameter int RATE_W   = 4,
  parameter int LOG_FAST = 13,
  parameter int BASE_LOG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [CNT_W-1:0]  now_cnt,
  input  logic [4:0]        cur_hr,
  input  logic [5:0]        cur_min,
  input  logic [5:0]        cur_sec,
  input  logic [4:0]        alm_hr,
  input  logic [5:0]        alm_min,
  input  logic [5:0]        alm_sec,
  output logic              chan_en,
  output logic [CNT_W-1:0]  next_deadline,
  output logic [CNT_W-1:0]  lost_ticks,
  output logic              irq_strobe,
  output logic [15:0]       irq_status
);
  import rtc_emu_pkg::*;

  localparam int SH_W = RATE_W;
  localparam logic [RATE_W-1:0] BASE_R = RATE_W'(BASE_LOG);
  localparam logic [RATE_W-1:0] FAST_R = RATE_W'(LOG_FAST);

  logic [1:0]        rst_pipe;
  logic              rst_n_sync;
  logic              en_any_q, upd_q;
  logic [RATE_W-1:0] rate_q;
  logic              arm, go, upd_rise, rate_chg;
  logic [RATE_W-1:0] eff_rate;
  logic [SH_W-1:0]   shamt, lim_log;
  logic [CNT_W-1:0]  skip_n;
  logic              uf, af, pf, strobe_n;
  logic [15:0]       status_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  assign chan_en  = upd_en | alm_en | per_en;
  assign arm      = chan_en && !en_any_q;
  assign go       = tick && chan_en && !arm;
  assign upd_rise = upd_en && !upd_q;
  assign rate_chg = rate_sel != rate_q;

  always_comb begin
    eff_rate = BASE_R;
    if (per_en && rate_sel > BASE_R)
      eff_rate = (rate_sel > FAST_R) ? FAST_R : rate_sel;
    shamt   = SH_W'(FAST_R - eff_rate);
    lim_log = (rate_sel >= BASE_R) ? '0 : SH_W'(BASE_R - rate_sel);
  end

  rtc_tick_sched #(.CNT_W(CNT_W), .SH_W(SH_W)) u_sched (
    .clk(clk), .rst_n(rst_n_sync), .arm(arm), .go(go), .now(now_cnt),
    .shamt(shamt), .deadline(next_deadline), .skip_n(skip_n), .lost(lost_ticks)
  );

  rtc_pie_div #(.CNT_W(CNT_W), .SH_W(SH_W)) u_pie (
    .clk(clk), .rst_n(rst_n_sync), .clr(rate_chg), .go(go && per_en),
    .skip(skip_n), .lim_log(lim_log), .fire(pf)
  );

  rtc_flag_eval u_flags (
    .clk(clk), .rst_n(rst_n_sync), .go(go), .upd_en(upd_en), .upd_rise(upd_rise),
    .alm_en(alm_en), .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec), .uf(uf), .af(af)
  );

  assign strobe_n = uf | af | pf;
  assign status_n = pack_status(uf, af, pf);

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      en_any_q   <= 1'b0;
      upd_q      <= 1'b0;
      rate_q     <= '0;
      irq_strobe <= 1'b0;
      irq_status <= '0;
    end else begin
      en_any_q   <= chan_en;
      upd_q      <= upd_en;
      rate_q     <= rate_sel;
      irq_strobe <= strobe_n;
      if (strobe_n) irq_status <= status_n;
    end
  end
endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             tick,
  input logic             upd_en,
  input logic             alm_en,
  input logic             per_en,
  input logic             chan_en,
  input logic [CNT_W-1:0] now_cnt,
  input logic [CNT_W-1:0] next_deadline,
  input logic             irq_strobe,
  input logic [15:0]      irq_status
);
  // R1: no enable, no interrupt on the following clock
  a_r1_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!upd_en && !alm_en && !per_en) |=> !irq_strobe);

  // R6: a strobe only follows a tick
  a_r6_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !tick |=> !irq_strobe);

  // R6: packed word layout while strobing
  a_r6_status_form: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq_strobe |-> (irq_status[7] && irq_status[15:8] == 8'd1 &&
                    irq_status[6:4] != 3'd0 && irq_status[3:0] == 4'd0));

  // R6: word holds without a strobe
  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !irq_strobe |-> $stable(irq_status));

  // R7: deadline never left behind the serviced count
  a_r7_deadline_ahead: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tick && chan_en) |=> ($signed(next_deadline - $past(now_cnt)) >= 0));
endmodule

bind rtc_irq_emu rtc_irq_emu_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rtc_irq_emu_tb.sv
module rtc_irq_emu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, tick, upd_en, alm_en, per_en;
  logic [3:0]  rate_sel;
  logic [31:0] now_cnt;
  logic [4:0]  cur_hr, alm_hr;
  logic [5:0]  cur_min, cur_sec, alm_min, alm_sec;
  logic        chan_en, irq_strobe;
  logic [31:0] next_deadline, lost_ticks;
  logic [15:0] irq_status;

  rtc_irq_emu u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .upd_en(upd_en), .alm_en(alm_en),
    .per_en(per_en), .rate_sel(rate_sel), .now_cnt(now_cnt), .cur_hr(cur_hr),
    .cur_min(cur_min), .cur_sec(cur_sec), .alm_hr(alm_hr), .alm_min(alm_min),
    .alm_sec(alm_sec), .chan_en(chan_en), .next_deadline(next_deadline),
    .lost_ticks(lost_ticks), .irq_strobe(irq_strobe), .irq_status(irq_status)
  );

  typedef struct packed {
    logic        strobe;
    logic [15:0] status;
    logic [31:0] lost;
    logic [31:0] dl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0, n_fail = 0;
  logic  mon_pending;
  bit    done = 0;

  // reference state
  logic        m_u, m_a, m_p;
  logic [3:0]  m_sel;
  logic [31:0] m_dl, m_lost, m_pie;
  logic [5:0]  m_prev;
  logic        m_pv;
  logic [15:0] m_status;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] m_ivl(logic p, logic [3:0] sel);
    if (p && sel > 4'd6) return 32'd1 << (13 - ((sel > 4'd13) ? 13 : int'(sel)));
    return 32'd128;
  endfunction

  // monitor: compare serviced ticks against the scoreboard
  always @(posedge clk) mon_pending <= tick;
  always @(negedge clk) begin
    if (mon_pending && exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " strobe"}, {31'd0, irq_strobe}, {31'd0, e.strobe});
      chk({t, " status"}, {16'd0, irq_status}, {16'd0, e.status});
      chk({t, " lost"}, lost_ticks, e.lost);
      chk({t, " deadline"}, next_deadline, e.dl);
    end
  end

  task automatic set_cfg(logic u, logic a, logic p, logic [3:0] sel);
    @(negedge clk);
    if (!(m_u | m_a | m_p) && (u | a | p)) m_dl = now_cnt + m_ivl(p, sel);
    if (u && !m_u) m_pv = 1'b0;
    if (sel != m_sel) m_pie = '0;
    m_u = u; m_a = a; m_p = p; m_sel = sel;
    upd_en = u; alm_en = a; per_en = p; rate_sel = sel;
    @(negedge clk);
    chk("R2 deadline after config", next_deadline, m_dl);
    chk("R1 chan_en", {31'd0, chan_en}, {31'd0, u | a | p});
  endtask

  task automatic do_tick(logic [31:0] now, logic [4:0] h, logic [5:0] mi, logic [5:0] s, string tag);
    exp_t e;
    logic uf, af, pf;
    int   n;
    @(negedge clk);
    now_cnt = now; cur_hr = h; cur_min = mi; cur_sec = s; tick = 1'b1;
    uf = 0; af = 0; pf = 0;
    if (m_u | m_a | m_p) begin
      n = 0;
      do begin m_dl = m_dl + m_ivl(m_p, m_sel); n++; end
      while ($signed(now - m_dl) > 0);
      m_lost = 32'(n - 1);
      if (m_p) begin
        m_pie = m_pie + 32'(n);
        if (m_pie >= ((m_sel >= 4'd6) ? 32'd1 : (32'd1 << (6 - int'(m_sel))))) begin
          pf = 1; m_pie = '0;
        end
      end
      if (m_u && (!m_pv || s != m_prev)) begin
        uf = m_pv; m_prev = s; m_pv = 1'b1;
      end
      af = m_a && h == alm_hr && mi == alm_min && s == alm_sec;
    end
    if (uf | af | pf) m_status = {8'd1, 1'b1, pf, af, uf, 4'd0};
    e.strobe = uf | af | pf;
    e.status = m_status;
    e.lost   = m_lost;
    e.dl     = m_dl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; upd_en = 0; alm_en = 0; per_en = 0; rate_sel = 4'd6;
    now_cnt = 0; cur_hr = 0; cur_min = 0; cur_sec = 0;
    alm_hr = 5'd1; alm_min = 6'd2; alm_sec = 6'd3;
    m_u = 0; m_a = 0; m_p = 0; m_sel = 4'd6; m_dl = 0; m_lost = 0; m_pie = 0;
    m_prev = 0; m_pv = 0; m_status = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 strobe", {31'd0, irq_strobe}, 32'd0);
    chk("R10 status", {16'd0, irq_status}, 32'd0);
    chk("R10 deadline", next_deadline, 32'd0);
    chk("R10 lost", lost_ticks, 32'd0);

    // R1 ignored tick
    do_tick(32'd50, 0, 0, 0, "R1 tick while idle");

    // R2 arm, R4 first record suppressed, then update
    now_cnt = 32'd1000;
    set_cfg(1, 0, 0, 4'd6);
    do_tick(32'd1128, 0, 0, 10, "R4 first record");
    do_tick(32'd1256, 0, 0, 10, "R4 same second");
    do_tick(32'd1384, 0, 0, 11, "R4 update");

    // R5 alarm
    set_cfg(1, 1, 0, 4'd6);
    do_tick(32'd1512, 1, 2, 3, "R5 alarm match");
    do_tick(32'd1640, 1, 2, 4, "R5 alarm miss");

    // R3 slow periodic, 16 Hz -> every 4th tick
    set_cfg(0, 0, 1, 4'd4);
    for (int i = 0; i < 5; i++) do_tick(32'd1768 + 32'(i) * 128, 1, 2, 4, "R3 div4");

    // R2 fast periodic, 1024 Hz -> interval 8
    set_cfg(0, 0, 1, 4'd10);
    do_tick(next_deadline, 0, 0, 0, "R2 fast tick");
    do_tick(next_deadline + 8, 0, 0, 0, "R2 fast tick 2");
    do_tick(next_deadline - 3, 0, 0, 0, "R7 early tick");
    // R7 late tick
    do_tick(next_deadline + 50, 0, 0, 0, "R7 late fast");

    // R8 skipped folding at 4 Hz (limit 16)
    set_cfg(0, 0, 1, 4'd2);
    do_tick(next_deadline + 1285, 0, 0, 0, "R8 late no fire");
    do_tick(next_deadline, 0, 0, 0, "R8 punctual");
    do_tick(next_deadline + 640, 0, 0, 0, "R8 late fire");

    // R9 rate change restarts count
    set_cfg(0, 0, 1, 4'd3);
    for (int i = 0; i < 3; i++) do_tick(next_deadline, 0, 0, 0, "R9 pre change");
    set_cfg(0, 0, 1, 4'd4);
    for (int i = 0; i < 4; i++) do_tick(next_deadline, 0, 0, 0, "R9 after change");

    // R1 full disable then re-arm
    set_cfg(0, 0, 0, 4'd4);
    do_tick(next_deadline + 500, 0, 0, 0, "R1 disabled tick");
    now_cnt = 32'd90000;
    set_cfg(0, 0, 1, 4'd6);
    do_tick(next_deadline, 0, 0, 0, "R3 64Hz every tick");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule